// File: doc/BRIEF.md
# Audio Playback Control and Status Register

This block keeps the control state of an audio streaming path. The state is an 8-bit status register, the pause/play and repeat flags, a free-running playback sample pointer and a host-loaded read pointer. A command decoder in front of the block turns host bytes into one opcode strobe, `cmd_stb` with `cmd_op`, plus a 16-bit payload whose first received byte sits in `cmd_pay[15:8]`. A game-side bus interface raises request pulses. These pulses mark bits in the register until the host clears them.

The block assembles the 16-bit status word that the decoder sends back to the host. That word packs the DMA busy input, the top bits of both pointers and the status byte. A separate feature-enable nibble is kept for the decoders further down the chip. The serial link, the audio DAC datapath and the storage DMA engine live outside this block.

Top module: `apu_ctrl_status`

## Requirements
- R1: After reset the status word (with `dma_busy` low), both pointers and the feature nibble are all zero.
- R2: Opcode 0xE0 ORs `cmd_pay[15:8]` into the status byte and then clears every bit that is set in `cmd_pay[7:0]`. When a bit appears in both masks, it ends up cleared.
- R3: Only status bits 5, 4, 2, 1 and 0 can be written. Bits 12 to 6 and bit 3 of the status word always read zero, whatever the masks hold.
- R4: Opcode 0xE1 clears the play bit (bit 1) and opcode 0xE2 sets it. Neither opcode changes any other status bit.
- R5: While bit 1 is set, each `sample_stb` pulse advances `dac_ptr` by one, wrapping modulo 2^DAC_W. While bit 1 is clear, the pointer holds its value.
- R6: Opcode 0xE3 clears `dac_ptr`. This takes priority over a sample advance in the same cycle.
- R7: Opcode 0xE4 loads `rd_ptr` from `cmd_pay`, high byte first. Status word bit 13 equals the MSB of `rd_ptr`.
- R8: Status word bit 15 follows `dma_busy` in the same cycle. Bit 14 equals the MSB of `dac_ptr`.
- R9: Pulses on `game_areq`, `game_dreq` and `game_creq` set status bits 5, 4 and 0 respectively. A set bit stays set until a 0xE0 clear mask removes it. A pulse beats a clear of the same bit in the same cycle.
- R10: Opcode 0xED writes `cmd_pay[11:8]` to `feat_en`. Bit 3 enables the audio registers, bit 2 the clock registers, and bits 1 and 0 two coprocessor mappings. `cmd_pay[15:12]` is ignored.
- R11: A strobe whose opcode is not one of those listed above changes no status bit, pointer or feature bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_op | input | 8 | Decoded opcode |
| cmd_pay | input | 16 | Payload, first byte in [15:8] |
| sample_stb | input | 1 | Audio sample tick |
| game_areq | input | 1 | Game-side audio request pulse |
| game_dreq | input | 1 | Game-side data request pulse |
| game_creq | input | 1 | Game-side audio control request pulse |
| dma_busy | input | 1 | Storage DMA busy flag |
| status_word | output | 16 | Packed status word |
| dac_ptr | output | DAC_W | Playback sample pointer |
| rd_ptr | output | RD_W | Host-loaded read pointer |
| feat_en | output | 4 | Feature enable bits |

## Verification
The mask command is swept over all 256 set masks. Each set mask is paired with a scrambled clear mask, so the bench sees overlapping, disjoint and reserved-bit patterns, and these separate set-then-clear ordering from the reverse. The sample pointer is stepped past its wrap point on a 4-bit configuration while playing, and again while paused; this shows whether the pointer advances, wraps and freezes at the right times. Same-cycle collisions are driven on purpose: a request pulse against its clear, and a pointer clear against a sample tick. These collisions are the only patterns that reveal the priority order. The feature nibble is written through every value, with noise in the ignored payload bits.

// File: rtl/apu_ctrl_pkg.sv
package apu_ctrl_pkg;
  localparam logic [7:0] OP_MASK    = 8'hE0;
  localparam logic [7:0] OP_PAUSE   = 8'hE1;
  localparam logic [7:0] OP_PLAY    = 8'hE2;
  localparam logic [7:0] OP_PTR_CLR = 8'hE3;
  localparam logic [7:0] OP_RD_LOAD = 8'hE4;
  localparam logic [7:0] OP_FEAT    = 8'hED;

  localparam int B_CREQ = 0;
  localparam int B_PLAY = 1;
  localparam int B_RPT  = 2;
  localparam int B_DREQ = 4;
  localparam int B_AREQ = 5;

  localparam logic [7:0] STAT_WR = 8'h37;

  typedef struct packed {
    logic mask_wr;
    logic pause;
    logic play;
    logic ptr_clr;
    logic rd_load;
    logic feat_wr;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic stb, input logic [7:0] op);
    cmd_dec_t d;
    d.mask_wr = stb && (op == OP_MASK);
    d.pause   = stb && (op == OP_PAUSE);
    d.play    = stb && (op == OP_PLAY);
    d.ptr_clr = stb && (op == OP_PTR_CLR);
    d.rd_load = stb && (op == OP_RD_LOAD);
    d.feat_wr = stb && (op == OP_FEAT);
    return d;
  endfunction

  function automatic logic [7:0] mask_update(input logic [7:0] cur,
                                             input logic [7:0] setm,
                                             input logic [7:0] clrm);
    return ((cur | setm) & ~clrm) & STAT_WR;
  endfunction

  function automatic logic [15:0] pack_word(input logic busy, input logic dac_msb,
                                            input logic rd_msb, input logic [7:0] stat);
    return {busy, dac_msb, rd_msb, 5'b0, stat & STAT_WR};
  endfunction
endpackage

// File: rtl/apu_stat_reg.sv
module apu_stat_reg
  import apu_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_wr,
  input  logic       pause,
  input  logic       play,
  input  logic [7:0] set_m,
  input  logic [7:0] clr_m,
  input  logic       areq_p,
  input  logic       dreq_p,
  input  logic       creq_p,
  output logic [7:0] stat
);
  logic [7:0] stat_q, stat_d, pulse_vec;

  always_comb begin
    pulse_vec = '0;
    pulse_vec[B_AREQ] = areq_p;
    pulse_vec[B_DREQ] = dreq_p;
    pulse_vec[B_CREQ] = creq_p;
  end

  always_comb begin
    stat_d = stat_q;
    if (mask_wr) stat_d = mask_update(stat_q, set_m, clr_m);
    if (pause)   stat_d[B_PLAY] = 1'b0;
    if (play)    stat_d[B_PLAY] = 1'b1;
    stat_d = stat_d | pulse_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~STAT_WR) == 8'h00);
  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && clr_m[B_RPT]) |=> !stat_q[B_RPT]);
  // R9
  areq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    areq_p |=> stat_q[B_AREQ]);
  // R4
  pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !mask_wr) |=> !stat_q[B_PLAY]);
endmodule

// File: rtl/apu_ptrs.sv
module apu_ptrs #(
  parameter int DAC_W = 11,
  parameter int RD_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_clr,
  input  logic             rd_load,
  input  logic [RD_W-1:0]  rd_val,
  input  logic             sample_stb,
  input  logic             playing,
  output logic [DAC_W-1:0] dac_ptr,
  output logic [RD_W-1:0]  rd_ptr
);
  logic [DAC_W-1:0] dac_q;
  logic [RD_W-1:0]  rd_q;
  logic             dac_step;

  assign dac_step = sample_stb && playing && !ptr_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)        dac_q <= '0;
    else if (ptr_clr)  dac_q <= '0;
    else if (dac_step) dac_q <= dac_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= rd_val;
  end

  assign dac_ptr = dac_q;
  assign rd_ptr  = rd_q;

  // R5
  dac_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && playing && !ptr_clr) |=> dac_q == DAC_W'($past(dac_q) + 1'b1));
  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sample_stb && playing) && !ptr_clr) |=> $stable(dac_q));
  // R6
  dac_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> dac_q == '0);
  // R7
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> rd_q == $past(rd_val));
endmodule

// File: rtl/apu_feat_reg.sv
module apu_feat_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       feat_wr,
  input  logic [3:0] feat_val,
  output logic [3:0] feat_en
);
  logic [3:0] feat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       feat_q <= '0;
    else if (feat_wr) feat_q <= feat_val;
  end

  assign feat_en = feat_q;

  // R10
  feat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feat_wr |=> feat_q == $past(feat_val));
  // R11
  feat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_wr |=> $stable(feat_q));
endmodule

// File: rtl/apu_ctrl_status.sv
module apu_ctrl_status
  import apu_ctrl_pkg::*;
#(
  parameter int DAC_W = 11,
  parameter int RD_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [7:0]       cmd_op,
  input  logic [15:0]      cmd_pay,
  input  logic             sample_stb,
  input  logic             game_areq,
  input  logic             game_dreq,
  input  logic             game_creq,
  input  logic             dma_busy,
  output logic [15:0]      status_word,
  output logic [DAC_W-1:0] dac_ptr,
  output logic [RD_W-1:0]  rd_ptr,
  output logic [3:0]       feat_en
);
  localparam int DAC_MSB = DAC_W - 1;
  localparam int RD_MSB  = RD_W - 1;

  cmd_dec_t   dec;
  logic [7:0] stat;

  assign dec = decode_cmd(cmd_stb, cmd_op);

  apu_stat_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_wr (dec.mask_wr),
    .pause   (dec.pause),
    .play    (dec.play),
    .set_m   (cmd_pay[15:8]),
    .clr_m   (cmd_pay[7:0]),
    .areq_p  (game_areq),
    .dreq_p  (game_dreq),
    .creq_p  (game_creq),
    .stat    (stat)
  );

  apu_ptrs #(.DAC_W(DAC_W), .RD_W(RD_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_clr    (dec.ptr_clr),
    .rd_load    (dec.rd_load),
    .rd_val     (cmd_pay[RD_W-1:0]),
    .sample_stb (sample_stb),
    .playing    (stat[B_PLAY]),
    .dac_ptr    (dac_ptr),
    .rd_ptr     (rd_ptr)
  );

  apu_feat_reg u_feat (
    .clk      (clk),
    .rst_n    (rst_n),
    .feat_wr  (dec.feat_wr),
    .feat_val (cmd_pay[11:8]),
    .feat_en  (feat_en)
  );

  assign status_word = pack_word(dma_busy, dac_ptr[DAC_MSB], rd_ptr[RD_MSB], stat);

  // R11
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !(dec.mask_wr || dec.pause || dec.play || dec.ptr_clr || dec.rd_load || dec.feat_wr)
     && !game_areq && !game_dreq && !game_creq) |=> $stable(stat));
endmodule

// File: tb/apu_ctrl_status_tb.sv
module apu_ctrl_status_tb_top;
  localparam int DW = 4;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_stb = 1'b0;
  logic [7:0] cmd_op = '0;
  logic [15:0] cmd_pay = '0;
  logic sample_stb = 1'b0, game_areq = 1'b0, game_dreq = 1'b0, game_creq = 1'b0, dma_busy = 1'b0;
  logic [15:0] status_word;
  logic [DW-1:0] dac_ptr;
  logic [RW-1:0] rd_ptr;
  logic [3:0] feat_en;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_stat = '0;
  int m_dac = 0;
  int m_rd = 0;
  int m_feat = 0;
  bit done = 0;

  always #2 clk = ~clk;

  apu_ctrl_status #(.DAC_W(DW), .RD_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_pay(cmd_pay),
    .sample_stb(sample_stb), .game_areq(game_areq), .game_dreq(game_dreq),
    .game_creq(game_creq), .dma_busy(dma_busy), .status_word(status_word),
    .dac_ptr(dac_ptr), .rd_ptr(rd_ptr), .feat_en(feat_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_word();
    return (int'(dma_busy) * 32768) + ((m_dac / (1 << (DW - 1))) % 2) * 16384
         + ((m_rd / 32768) % 2) * 8192 + int'(m_stat);
  endfunction

  task automatic chk_all(input string req);
    chk(req, status_word, exp_word());
    chk(req, dac_ptr, m_dac);
    chk(req, rd_ptr, m_rd);
    chk(req, feat_en, m_feat);
  endtask

  task automatic cyc(input logic stb, input logic [7:0] op, input logic [15:0] pay,
                     input logic smp, input logic a, input logic d, input logic c);
    cmd_stb = stb; cmd_op = op; cmd_pay = pay;
    sample_stb = smp; game_areq = a; game_dreq = d; game_creq = c;
    @(negedge clk);
    cmd_stb = 0; cmd_op = 0; cmd_pay = 0;
    sample_stb = 0; game_areq = 0; game_dreq = 0; game_creq = 0;
  endtask

  task automatic cmd(input logic [7:0] op, input logic [15:0] pay);
    cyc(1'b1, op, pay, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic mask(input int s, input int r);
    cmd(8'hE0, 16'((s % 256) * 256 + (r % 256)));
    m_stat = 8'((((int'(m_stat) | (s % 256)) & ~(r % 256))) % 256) & 8'b0011_0111;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");

    dma_busy = 1'b1; #1;
    chk("R8 busy", status_word, exp_word());
    dma_busy = 1'b0; #1;
    chk("R8 idle", status_word, exp_word());

    for (int i = 0; i < 256; i++) begin
      mask(i, (i * 37 + 11) % 256);
      chk("R2 R3 mask sweep", status_word, exp_word());
    end
    mask(8'hFF, 8'h02);
    chk("R2 overlap clear wins", status_word, exp_word());

    mask(0, 8'hFF);
    mask(8'h04, 0);
    cmd(8'hE2, 16'hFFFF); m_stat[1] = 1;
    chk("R4 play", status_word, exp_word());
    cmd(8'hE1, 16'hFFFF); m_stat[1] = 0;
    chk("R4 pause", status_word, exp_word());

    cmd(8'hE2, 0); m_stat[1] = 1;
    for (int k = 0; k < 21; k++) begin
      cyc(0, 0, 0, 1, 0, 0, 0);
      m_dac = (m_dac + 1) % (1 << DW);
      chk("R5 R8 advance", dac_ptr, m_dac);
      chk("R8 dac msb", status_word, exp_word());
    end
    cmd(8'hE1, 0); m_stat[1] = 0;
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 1, 0, 0, 0);
      chk("R5 frozen", dac_ptr, m_dac);
    end
    cmd(8'hE2, 0); m_stat[1] = 1;
    cyc(1, 8'hE3, 0, 1, 0, 0, 0); m_dac = 0;
    chk("R6 clear beats tick", dac_ptr, 0);
    cyc(0, 0, 0, 1, 0, 0, 0); m_dac = 1;
    cmd(8'hE3, 0); m_dac = 0;
    chk_all("R6 clear");

    for (int v = 0; v < 8; v++) begin
      m_rd = (v * 20011 + 4660) % 65536;
      cmd(8'hE4, 16'(m_rd));
      chk_all("R7 load");
    end

    cyc(0, 0, 0, 0, 1, 0, 0); m_stat[5] = 1;
    chk("R9 areq", status_word, exp_word());
    cyc(0, 0, 0, 0, 0, 1, 1); m_stat[4] = 1; m_stat[0] = 1;
    chk("R9 dreq creq", status_word, exp_word());
    cyc(1, 8'hE0, 16'h0031, 0, 1, 0, 0); m_stat[4] = 0; m_stat[0] = 0;
    chk("R9 pulse beats clear", status_word, exp_word());
    mask(0, 8'h20);
    chk("R9 host clear", status_word, exp_word());

    for (int f = 0; f < 16; f++) begin
      cmd(8'hED, 16'(((f * 5 + 3) % 16) * 4096 + f * 256 + 255));
      m_feat = f;
      chk("R10 feature", feat_en, m_feat);
    end

    cmd(8'hE5, 16'hFFFF); chk_all("R11 unknown E5");
    cmd(8'h00, 16'hFFFF); chk_all("R11 unknown 00");
    cmd(8'hEF, 16'h0000); chk_all("R11 unknown EF");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule